// File: doc/BRIEF.md
# Operand Read Stage with Demand-Driven Register File Access

This block is the operand-read stage, with its hazard interlock, of a six-stage in-order pipeline. The stages are fetch, decode, operand read, execute 1, execute 2 and write-back. Each instruction in the stage names up to two source registers. For each source, the block first checks whether the value can come from the forwarding network. It enables a register-file read port for that source only when forwarding cannot supply it, so the file is never read ahead of need. Destinations are written back in the write-back stage.

There is one forwarding path. It carries the result latched at the output of execute 1, and it feeds only the second source port. The first source port always takes its value from the register file. A source whose value is not yet obtainable stalls the stage: the stage holds its instruction, holds fetch and decode, and sends an empty slot into execute 1. The block keeps running counts of enabled register-file reads, register-file writes and forwarding hits. These counts serve as the register-file energy figure for the running code.

Distance is counted in instructions. An instruction at distance 1 issued just ahead of the consumer; an instruction at distance 2 has one instruction between it and the consumer, and so on.

Top module: `opr_stage`

## Requirements
- R1: While reset is held and right after it is released, `stall`, `iss_valid`, both read enables, `byp_sel_b` and `rf_we` are low, and all three counters read zero.
- R2: A second-port source is forwarded, with `byp_sel_b` high and `rf_re_b` low, when its writing producer is at distance 2. At distance 2 the producer's result sits in the execute-1 output latch.
- R3: A used second-port source with no writing producer at distance 1 or 2 raises `rf_re_b`, with `rf_ra_b` equal to the source register.
- R4: A used source whose writing producer is at distance 1 (still in execute 1) stalls the stage on either port. An empty slot goes into execute 1. For the second port, the next cycle is a forwarding hit.
- R5: The first port never uses forwarding. A first-port source whose producer is at distance 1 or 2 stalls the stage. It is read through `rf_re_a` once the producer reaches write-back, which means two stall cycles for an adjacent producer.
- R6: When a source is read in the same cycle that write-back writes that register, the stage does not stall. The read counts as one register-file access, and the write is seen on `rf_we`/`rf_wa` in that same cycle.
- R7: When several in-flight instructions write the source register, the newest one decides the outcome.
- R8: A source whose use flag is low causes no read, no forwarding hit and no stall.
- R9: Each writing instruction raises `rf_we` with its destination exactly three cycles after it issues. Stall bubbles and instructions that do not write produce no write and no forwarding.
- R10: `rd_cnt` adds every enabled read on either port, `wr_cnt` every write and `hit_cnt` every forwarding hit. `rd_cnt + hit_cnt` equals the number of source operands consumed by issued instructions.
- R11: Register 0 is tracked and forwarded exactly like every other register.
- R12: During a stall, the decode inputs are ignored and the stalled instruction's register addresses stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode offers an instruction |
| dec_use_a | input | 1 | First source is used |
| dec_src_a | input | REG_W | First source register |
| dec_use_b | input | 1 | Second source is used |
| dec_src_b | input | REG_W | Second source register |
| dec_wr | input | 1 | Instruction writes a destination |
| dec_dst | input | REG_W | Destination register |
| stall | output | 1 | Operand-read stage stalled; fetch and decode hold |
| iss_valid | output | 1 | Instruction leaves operand read into execute 1 |
| rf_re_a | output | 1 | First read port enable |
| rf_ra_a | output | REG_W | First read port address |
| rf_re_b | output | 1 | Second read port enable |
| rf_ra_b | output | REG_W | Second read port address |
| byp_sel_b | output | 1 | Second operand taken from forwarding |
| rf_we | output | 1 | Register-file write enable (write-back) |
| rf_wa | output | REG_W | Register-file write address |
| rd_cnt | output | CNT_W | Enabled register-file reads |
| wr_cnt | output | CNT_W | Register-file writes |
| hit_cnt | output | CNT_W | Forwarding hits on the second port |

## Verification
The bench builds the block with REG_W = 3. With only eight register names, random instruction streams keep colliding with the destinations in flight. Those collisions exercise every mix of distance-1 stalls, distance-2 forwarding and write-back write-through, with register 0 included. CNT_W stays at 16 because the run is far too short to wrap a counter. Directed sequences pin the exact stall lengths and counter steps for each distance on each port.

// File: rtl/opr_pkg.sv
package opr_pkg;

    // Where a source operand will come from in the current cycle.
    typedef enum logic [1:0] {
        OPS_NONE = 2'd0,   // source unused
        OPS_FILE = 2'd1,   // read the register file
        OPS_FWD  = 2'd2,   // take the execute-1 output latch
        OPS_WAIT = 2'd3    // not obtainable yet: stall
    } opsrc_e;

endpackage

// File: rtl/opr_src_resolve.sv
module opr_src_resolve
    import opr_pkg::*;
#(
    parameter int REG_W  = 5,
    parameter bit FWD_OK = 1'b0
) (
    input  logic             use_i,
    input  logic [REG_W-1:0] tag_i,
    input  logic             x1_live_i,
    input  logic [REG_W-1:0] x1_dst_i,
    input  logic             x2_live_i,
    input  logic [REG_W-1:0] x2_dst_i,
    output opsrc_e           kind_o
);

    logic hit_x1;
    logic hit_x2;

    assign hit_x1 = x1_live_i && (x1_dst_i == tag_i);
    assign hit_x2 = x2_live_i && (x2_dst_i == tag_i);

    // The newest producer is checked first.
    generate
        if (FWD_OK) begin : g_fwd
            always_comb begin
                if (!use_i)      kind_o = OPS_NONE;
                else if (hit_x1) kind_o = OPS_WAIT;
                else if (hit_x2) kind_o = OPS_FWD;
                else             kind_o = OPS_FILE;
            end
        end else begin : g_file_only
            always_comb begin
                if (!use_i)                kind_o = OPS_NONE;
                else if (hit_x1 || hit_x2) kind_o = OPS_WAIT;
                else                       kind_o = OPS_FILE;
            end
        end
    endgenerate

endmodule

// File: rtl/opr_tag_pipe.sv
module opr_tag_pipe #(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_live,
    input  logic [REG_W-1:0] in_dst,
    output logic             x1_live,
    output logic [REG_W-1:0] x1_dst,
    output logic             x2_live,
    output logic [REG_W-1:0] x2_dst,
    output logic             wb_live,
    output logic [REG_W-1:0] wb_dst
);

    typedef struct packed {
        logic             live;
        logic [REG_W-1:0] dst;
    } slot_t;

    typedef struct packed {
        slot_t x1;
        slot_t x2;
        slot_t wb;
    } pipe_t;

    pipe_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.x1.live = in_live;
        st_d.x1.dst  = in_dst;
        st_d.x2      = st_q.x1;
        st_d.wb      = st_q.x2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign x1_live = st_q.x1.live;
    assign x1_dst  = st_q.x1.dst;
    assign x2_live = st_q.x2.live;
    assign x2_dst  = st_q.x2.dst;
    assign wb_live = st_q.wb.live;
    assign wb_dst  = st_q.wb.dst;

endmodule

// File: rtl/opr_access_cnt.sv
module opr_access_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_a,
    input  logic             rd_b,
    input  logic             hit,
    input  logic             wr,
    output logic [CNT_W-1:0] rd_cnt,
    output logic [CNT_W-1:0] wr_cnt,
    output logic [CNT_W-1:0] hit_cnt
);

    typedef struct packed {
        logic [CNT_W-1:0] rd;
        logic [CNT_W-1:0] wr;
        logic [CNT_W-1:0] hit;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d     = c_q;
        c_d.rd  = c_q.rd + CNT_W'(rd_a) + CNT_W'(rd_b);
        c_d.wr  = c_q.wr + CNT_W'(wr);
        c_d.hit = c_q.hit + CNT_W'(hit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign rd_cnt  = c_q.rd;
    assign wr_cnt  = c_q.wr;
    assign hit_cnt = c_q.hit;

endmodule

// File: rtl/opr_stage.sv
module opr_stage
    import opr_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_valid,
    input  logic             dec_use_a,
    input  logic [REG_W-1:0] dec_src_a,
    input  logic             dec_use_b,
    input  logic [REG_W-1:0] dec_src_b,
    input  logic             dec_wr,
    input  logic [REG_W-1:0] dec_dst,
    output logic             stall,
    output logic             iss_valid,
    output logic             rf_re_a,
    output logic [REG_W-1:0] rf_ra_a,
    output logic             rf_re_b,
    output logic [REG_W-1:0] rf_ra_b,
    output logic             byp_sel_b,
    output logic             rf_we,
    output logic [REG_W-1:0] rf_wa,
    output logic [CNT_W-1:0] rd_cnt,
    output logic [CNT_W-1:0] wr_cnt,
    output logic [CNT_W-1:0] hit_cnt
);

    localparam int NPORT = 2;

    typedef struct packed {
        logic             valid;
        logic             use_a;
        logic [REG_W-1:0] src_a;
        logic             use_b;
        logic [REG_W-1:0] src_b;
        logic             wr;
        logic [REG_W-1:0] dst;
    } orslot_t;

    orslot_t or_d, or_q;

    logic             x1_live, x2_live, wb_live;
    logic [REG_W-1:0] x1_dst, x2_dst, wb_dst;

    logic [NPORT-1:0] p_use;
    logic [REG_W-1:0] p_tag  [NPORT];
    opsrc_e           p_kind [NPORT];

    assign p_use    = {or_q.valid & or_q.use_b, or_q.valid & or_q.use_a};
    assign p_tag[0] = or_q.src_a;
    assign p_tag[1] = or_q.src_b;

    // Port 0 has no forwarding path; port 1 taps the execute-1 output latch.
    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            opr_src_resolve #(
                .REG_W (REG_W),
                .FWD_OK(p == 1)
            ) u_res (
                .use_i    (p_use[p]),
                .tag_i    (p_tag[p]),
                .x1_live_i(x1_live),
                .x1_dst_i (x1_dst),
                .x2_live_i(x2_live),
                .x2_dst_i (x2_dst),
                .kind_o   (p_kind[p])
            );
        end
    endgenerate

    always_comb begin
        stall     = (p_kind[0] == OPS_WAIT) || (p_kind[1] == OPS_WAIT);
        iss_valid = or_q.valid && !stall;
        rf_re_a   = iss_valid && (p_kind[0] == OPS_FILE);
        rf_re_b   = iss_valid && (p_kind[1] == OPS_FILE);
        byp_sel_b = iss_valid && (p_kind[1] == OPS_FWD);
        rf_ra_a   = or_q.src_a;
        rf_ra_b   = or_q.src_b;

        if (stall) begin
            or_d = or_q;
        end else begin
            or_d.valid = dec_valid;
            or_d.use_a = dec_use_a;
            or_d.src_a = dec_src_a;
            or_d.use_b = dec_use_b;
            or_d.src_b = dec_src_b;
            or_d.wr    = dec_wr;
            or_d.dst   = dec_dst;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) or_q <= '0;
        else        or_q <= or_d;
    end

    // A stall sends a cleared slot into execute 1.
    opr_tag_pipe #(
        .REG_W(REG_W)
    ) u_pipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_live(iss_valid && or_q.wr),
        .in_dst (or_q.dst),
        .x1_live(x1_live),
        .x1_dst (x1_dst),
        .x2_live(x2_live),
        .x2_dst (x2_dst),
        .wb_live(wb_live),
        .wb_dst (wb_dst)
    );

    assign rf_we = wb_live;
    assign rf_wa = wb_dst;

    opr_access_cnt #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_a   (rf_re_a),
        .rd_b   (rf_re_b),
        .hit    (byp_sel_b),
        .wr     (rf_we),
        .rd_cnt (rd_cnt),
        .wr_cnt (wr_cnt),
        .hit_cnt(hit_cnt)
    );

endmodule

// File: rtl/opr_stage_chk.sv
module opr_stage_chk #(
    parameter int REG_W = 5,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stall,
    input logic             rf_re_a,
    input logic [REG_W-1:0] rf_ra_a,
    input logic             rf_re_b,
    input logic [REG_W-1:0] rf_ra_b,
    input logic             byp_sel_b,
    input logic             rf_we,
    input logic [CNT_W-1:0] rd_cnt,
    input logic [CNT_W-1:0] wr_cnt,
    input logic [CNT_W-1:0] hit_cnt
);

    AST_B_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_re_b && byp_sel_b)); // R3

    AST_NO_ACCESS_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (!rf_re_a && !rf_re_b && !byp_sel_b)); // R4

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(rf_ra_a) && $stable(rf_ra_b))); // R12

    AST_RD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> rd_cnt == CNT_W'($past(rd_cnt) + CNT_W'($past(rf_re_a)) + CNT_W'($past(rf_re_b)))); // R10

    AST_WR_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> wr_cnt == CNT_W'($past(wr_cnt) + CNT_W'($past(rf_we)))); // R10

    AST_HIT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> hit_cnt == CNT_W'($past(hit_cnt) + CNT_W'($past(byp_sel_b)))); // R10

endmodule

bind opr_stage opr_stage_chk #(
    .REG_W(REG_W),
    .CNT_W(CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stall    (stall),
    .rf_re_a  (rf_re_a),
    .rf_ra_a  (rf_ra_a),
    .rf_re_b  (rf_re_b),
    .rf_ra_b  (rf_ra_b),
    .byp_sel_b(byp_sel_b),
    .rf_we    (rf_we),
    .rd_cnt   (rd_cnt),
    .wr_cnt   (wr_cnt),
    .hit_cnt  (hit_cnt)
);

// File: tb/opr_stage_bench.sv
module opr_stage_bench;

    localparam int RW = 3;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dec_valid = 1'b0, dec_use_a = 1'b0, dec_use_b = 1'b0, dec_wr = 1'b0;
    logic [RW-1:0] dec_src_a = '0, dec_src_b = '0, dec_dst = '0;
    logic          stall, iss_valid, rf_re_a, rf_re_b, byp_sel_b, rf_we;
    logic [RW-1:0] rf_ra_a, rf_ra_b, rf_wa;
    logic [CW-1:0] rd_cnt, wr_cnt, hit_cnt;

    opr_stage #(.REG_W(RW), .CNT_W(CW)) u_opr_stage (
        .clk(clk), .rst_n(rst_n),
        .dec_valid(dec_valid), .dec_use_a(dec_use_a), .dec_src_a(dec_src_a),
        .dec_use_b(dec_use_b), .dec_src_b(dec_src_b), .dec_wr(dec_wr), .dec_dst(dec_dst),
        .stall(stall), .iss_valid(iss_valid),
        .rf_re_a(rf_re_a), .rf_ra_a(rf_ra_a), .rf_re_b(rf_re_b), .rf_ra_b(rf_ra_b),
        .byp_sel_b(byp_sel_b), .rf_we(rf_we), .rf_wa(rf_wa),
        .rd_cnt(rd_cnt), .wr_cnt(wr_cnt), .hit_cnt(hit_cnt)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Bench-side model of the stage occupancy.
    bit          m_v, m_ua, m_ub, m_w;
    bit [RW-1:0] m_sa, m_sb, m_d;
    bit          m_x1l, m_x2l, m_wbl;
    bit [RW-1:0] m_x1d, m_x2d, m_wbd;
    int          m_rd, m_wr, m_hit, m_cons;
    int          nstall;
    bit          wt_seen;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // 0 unused, 1 file, 2 forward, 3 wait
    function automatic int mkind(input bit u, input bit [RW-1:0] s, input bit port_b);
        if (!u) return 0;
        if (m_x1l && m_x1d == s) return 3;
        if (m_x2l && m_x2d == s) return port_b ? 2 : 3;
        return 1;
    endfunction

    task automatic cyc(input bit v, input bit ua, input bit [RW-1:0] sa, input bit ub,
                       input bit [RW-1:0] sb, input bit w, input bit [RW-1:0] d, output bit st);
        int ka, kb;
        bit es, ea, eb, eh;
        dec_valid = v; dec_use_a = ua; dec_src_a = sa; dec_use_b = ub;
        dec_src_b = sb; dec_wr = w; dec_dst = d;
        #5;
        ka = mkind(m_v & m_ua, m_sa, 1'b0);
        kb = mkind(m_v & m_ub, m_sb, 1'b1);
        es = (ka == 3) || (kb == 3);
        ea = !es && ka == 1;
        eb = !es && kb == 1;
        eh = !es && kb == 2;
        chk(stall == es, "R4 stall", stall, es);
        chk(rf_re_a == ea, "R5 rf_re_a", rf_re_a, ea);
        chk(rf_re_b == eb, "R3 rf_re_b", rf_re_b, eb);
        chk(byp_sel_b == eh, "R2 byp_sel_b", byp_sel_b, eh);
        chk(iss_valid == (m_v && !es), "R12 iss_valid", iss_valid, m_v && !es);
        chk(rf_we == m_wbl, "R9 rf_we", rf_we, m_wbl);
        if (m_wbl) chk(rf_wa == m_wbd, "R9 rf_wa", rf_wa, m_wbd);
        if (ea) chk(rf_ra_a == m_sa, "R5 rf_ra_a", rf_ra_a, m_sa);
        if (eb) chk(rf_ra_b == m_sb, "R3 rf_ra_b", rf_ra_b, m_sb);
        chk(int'(rd_cnt) == m_rd, "R10 rd_cnt", rd_cnt, m_rd);
        chk(int'(wr_cnt) == m_wr, "R10 wr_cnt", wr_cnt, m_wr);
        chk(int'(hit_cnt) == m_hit, "R10 hit_cnt", hit_cnt, m_hit);
        if (rf_re_a && rf_we && rf_wa == rf_ra_a) wt_seen = 1;
        st = es;
        if (es) begin
            // R12: garbage on the decode inputs while stalled must be ignored
            dec_valid = 1'b1; dec_use_a = 1'($urandom); dec_src_a = RW'($urandom);
            dec_use_b = 1'($urandom); dec_src_b = RW'($urandom);
            dec_wr = 1'b1; dec_dst = RW'($urandom);
        end
        @(posedge clk);
        m_rd   += int'(ea) + int'(eb);
        m_hit  += int'(eh);
        m_wr   += int'(m_wbl);
        m_cons += int'(ea) + int'(eb) + int'(eh);
        m_wbl = m_x2l; m_wbd = m_x2d;
        m_x2l = m_x1l; m_x2d = m_x1d;
        m_x1l = m_v && !es && m_w; m_x1d = m_d;
        if (!es) begin
            m_v = v; m_ua = ua; m_sa = sa; m_ub = ub; m_sb = sb; m_w = w; m_d = d;
        end
        @(negedge clk);
    endtask

    task automatic push(input bit v, input bit ua, input bit [RW-1:0] sa, input bit ub,
                        input bit [RW-1:0] sb, input bit w, input bit [RW-1:0] d);
        bit st;
        do begin
            cyc(v, ua, sa, ub, sb, w, d, st);
            if (st) nstall++;
        end while (st);
    endtask

    task automatic nop();
        push(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic flush();
        repeat (4) nop();
    endtask

    // Snapshot of counters at the start of a directed sequence.
    int s_rd, s_wr, s_hit;
    task automatic begin_seq();
        flush();
        s_rd = int'(rd_cnt); s_wr = int'(wr_cnt); s_hit = int'(hit_cnt);
        nstall = 0; wt_seen = 0;
    endtask

    task automatic end_seq(input string req, input int e_st, input int e_rd, input int e_hit);
        flush();
        chk(nstall == e_st, {req, " stall cycles"}, nstall, e_st);
        chk(int'(rd_cnt) - s_rd == e_rd, {req, " reads"}, int'(rd_cnt) - s_rd, e_rd);
        chk(int'(hit_cnt) - s_hit == e_hit, {req, " hits"}, int'(hit_cnt) - s_hit, e_hit);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held
        chk(stall == 0 && iss_valid == 0, "R1 stall/issue in reset", stall, 0);
        chk(rf_re_a == 0 && rf_re_b == 0 && byp_sel_b == 0 && rf_we == 0, "R1 enables in reset", rf_re_a, 0);
        chk(rd_cnt == 0 && wr_cnt == 0 && hit_cnt == 0, "R1 counters in reset", rd_cnt, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(stall == 0 && rf_we == 0 && hit_cnt == 0, "R1 after release", stall, 0);

        // R4 + R2: second-port consumer right behind its producer
        begin_seq();
        push(1, 0, 0, 0, 0, 1, 3'd2);
        push(1, 0, 0, 1, 3'd2, 0, 0);
        end_seq("R4", 1, 0, 1);
        chk(int'(wr_cnt) - s_wr == 1, "R9 bubble writes nothing", int'(wr_cnt) - s_wr, 1);

        // R2: one unrelated instruction between producer and consumer
        begin_seq();
        push(1, 0, 0, 0, 0, 1, 3'd5);
        push(1, 0, 0, 0, 0, 1, 3'd6);
        push(1, 0, 0, 1, 3'd5, 0, 0);
        end_seq("R2", 0, 0, 1);

        // R5: first-port consumer right behind; junk on decode during stalls (R12)
        begin_seq();
        push(1, 0, 0, 0, 0, 1, 3'd1);
        push(1, 1, 3'd1, 0, 0, 0, 0);
        end_seq("R5", 2, 1, 0);
        chk(wt_seen == 1, "R6 write-through after R5 stall", wt_seen, 1);
        chk(int'(wr_cnt) - s_wr == 1, "R12 stalled decode input ignored", int'(wr_cnt) - s_wr, 1);

        // R5: first port, one instruction between: still a stall
        begin_seq();
        push(1, 0, 0, 0, 0, 1, 3'd7);
        push(1, 0, 0, 0, 0, 0, 0);
        push(1, 1, 3'd7, 0, 0, 0, 0);
        end_seq("R5 distance 2", 1, 1, 0);

        // R6: first port, producer in write-back at the read
        begin_seq();
        push(1, 0, 0, 0, 0, 1, 3'd3);
        push(1, 0, 0, 0, 0, 0, 0);
        push(1, 0, 0, 0, 0, 0, 0);
        push(1, 1, 3'd3, 0, 0, 0, 0);
        end_seq("R6", 0, 1, 0);
        chk(wt_seen == 1, "R6 write and read same cycle", wt_seen, 1);

        // R7: two producers of r4, newest at distance 2 wins over older one in write-back
        begin_seq();
        push(1, 0, 0, 0, 0, 1, 3'd4);
        push(1, 0, 0, 0, 0, 1, 3'd4);
        push(1, 0, 0, 0, 0, 0, 0);
        push(1, 0, 0, 1, 3'd4, 0, 0);
        end_seq("R7", 0, 0, 1);

        // R7: newest producer at distance 1 stalls even though an older one is forwardable
        begin_seq();
        push(1, 0, 0, 0, 0, 1, 3'd6);
        push(1, 0, 0, 0, 0, 1, 3'd6);
        push(1, 0, 0, 1, 3'd6, 0, 0);
        end_seq("R7 newest at distance 1", 1, 0, 1);

        // R11: register 0 behaves like any register
        begin_seq();
        push(1, 0, 0, 0, 0, 1, 3'd0);
        push(1, 0, 0, 1, 3'd0, 0, 0);
        end_seq("R11", 1, 0, 1);

        // R8: unused sources naming an in-flight destination
        begin_seq();
        push(1, 0, 0, 0, 0, 1, 3'd2);
        push(1, 0, 3'd2, 0, 3'd2, 0, 0);
        end_seq("R8", 0, 0, 0);

        // R3: both sources miss with nothing in flight
        begin_seq();
        push(1, 1, 3'd1, 1, 3'd2, 0, 0);
        end_seq("R3", 0, 2, 0);

        // Random stream
        for (int i = 0; i < 3000; i++) begin
            push(($urandom % 4) != 0, 1'($urandom), RW'($urandom), 1'($urandom),
                 RW'($urandom), 1'($urandom), RW'($urandom));
        end
        flush();
        chk(int'(rd_cnt) + int'(hit_cnt) == m_cons, "R10 reads plus hits equal operands",
            int'(rd_cnt) + int'(hit_cnt), m_cons);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule